// File: doc/BRIEF.md
# Wake Interrupt Register Controller

This block gathers the wake events of a small power-management domain behind a 32-bit register bus. Four wake channels, whose trigger detection is done outside the block, report events that are latched into a per-channel status register. A channel enable register selects which latched events raise one shared external interrupt. Software acknowledges an event by writing ones to a separate clear register.

Three peripheral wake sources are also handled: a real-time clock, an infrared receiver and a watchdog. A single route register holds two kinds of enable. The low half selects which sources are forwarded as interrupts. The high half selects which sources may raise the wake-up request. The wake-up request is the OR of every active source whose wake enable is set.

Register offsets: status 0x310 (read-only), enable 0x314, clear 0x318 (write-only), route 0x31C. A read returns its data on `rdata_o` in the cycle after the request.

Top module: `wkup_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, and `ext_irq_o`, `chan_irq_o`, `per_irq_o` and `wake_o` are all zero.
- R2: An event on `chan_evt_i[n]` sets status bit n at the next clock edge. The bit stays set after the event input falls.
- R3: A write to the clear register (0x318) clears each status bit n whose data bit n is 1. Bits written 0 are untouched. A read of 0x318 returns zero.
- R4: If an event and a clear for the same channel occur in the same cycle, the status bit stays set.
- R5: `ext_irq_o` is 1 exactly when some channel n has status bit n and enable bit n (0x314, bits 3:0) both set. Writing zero to the enable register drops `ext_irq_o` and leaves the status unchanged.
- R6: `chan_irq_o[n]` is status[n] AND enable[n] AND route bit 8+n.
- R7: `per_irq_o[k]` is `per_evt_i[k]` AND route bit k, where k = 0 is RTC, 1 is IR and 2 is watchdog.
- R8: `wake_o` is the OR of (status[n] AND route bit 24+n) over the four channels and of (`per_evt_i[k]` AND route bit 16+k) over the three peripherals.
- R9: Only route bits 2:0, 11:8, 18:16 and 27:24 and enable bits 3:0 are stored. All other bits of these registers read zero.
- R10: A read returns the register value on `rdata_o` one cycle after the request. An unmapped offset returns zero, and `rdata_o` is zero in any cycle that follows no read.
- R11: A write to the status offset (0x310) has no effect on the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| chan_evt_i | input | 4 | Wake-channel events from the detectors |
| per_evt_i | input | 3 | Peripheral events: RTC, IR, watchdog |
| ext_irq_o | output | 1 | Shared channel interrupt |
| chan_irq_o | output | 4 | Per-channel interrupt after external routing |
| per_irq_o | output | 3 | Peripheral interrupts after external routing |
| wake_o | output | 1 | Wake-up request |

## Verification
Register writes and channel events take effect at the clock edge where they are sampled. From then on the status-derived outputs (`ext_irq_o`, `chan_irq_o` and the channel part of `wake_o`) reflect them. Read data appears one edge after the request, and `per_irq_o` and the peripheral part of `wake_o` follow `per_evt_i` within the same cycle. The bench drives each stimulus on the falling edge and keeps a model of the pre-edge state. It checks every output one time unit after the next rising edge against that model, and the same-cycle set/clear collision is driven on purpose.

// File: rtl/wkup_irq_pkg.sv
package wkup_irq_pkg;
  localparam int unsigned N_CHAN = 4;
  localparam int unsigned N_PER  = 3;
  localparam int unsigned AW     = 12;
  localparam int unsigned DW     = 32;

  localparam logic [AW-1:0] OFF_STS = 12'h310;
  localparam logic [AW-1:0] OFF_EN  = 12'h314;
  localparam logic [AW-1:0] OFF_CLR = 12'h318;
  localparam logic [AW-1:0] OFF_RT  = 12'h31C;

  // route layout: ext-route low half, wake-enable high half
  localparam int unsigned RT_PER_EXT  = 0;
  localparam int unsigned RT_CHAN_EXT = 8;
  localparam int unsigned RT_PER_WK   = 16;
  localparam int unsigned RT_CHAN_WK  = 24;

  typedef struct packed {
    logic sts;
    logic en;
    logic clr;
    logic rt;
  } wr_sel_t;
endpackage

// File: rtl/wkup_chan_status.sv
module wkup_chan_status
  import wkup_irq_pkg::*;
#(
  parameter int unsigned NCH = N_CHAN
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic           wr_clr_i,
  input  logic [NCH-1:0] wdata_i,
  input  logic [NCH-1:0] evt_i,
  output logic [NCH-1:0] status_o,
  output logic [NCH-1:0] enable_o
);
  logic [NCH-1:0] clr_mask;
  assign clr_mask = wr_clr_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= '0;
      enable_o <= '0;
    end else begin
      // new event wins over a same-cycle clear
      status_o <= (status_o & ~clr_mask) | evt_i;
      if (wr_en_i) enable_o <= wdata_i;
    end
  end

  a_r2_event_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((status_o & $past(evt_i)) == $past(evt_i)));

  a_r4_set_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clr_i && ((evt_i & wdata_i) != '0)) |=> ((status_o & $past(evt_i & wdata_i)) != '0));

  a_r2_no_spurious_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_clr_i |=> ((status_o & $past(status_o)) == $past(status_o)));

  a_r3_clear_works: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clr_i && ((wdata_i & ~evt_i) != '0)) |=> ((status_o & $past(wdata_i & ~evt_i)) == '0));
endmodule

// File: rtl/wkup_route_reg.sv
module wkup_route_reg
  import wkup_irq_pkg::*;
#(
  parameter int unsigned NCH = N_CHAN,
  parameter int unsigned NPR = N_PER
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] route_o
);
  localparam logic [DW-1:0] PER_FIELD  = DW'((1 << NPR) - 1);
  localparam logic [DW-1:0] CHAN_FIELD = DW'((1 << NCH) - 1);
  localparam logic [DW-1:0] RT_MASK = (PER_FIELD << RT_PER_EXT) | (CHAN_FIELD << RT_CHAN_EXT)
                                    | (PER_FIELD << RT_PER_WK)  | (CHAN_FIELD << RT_CHAN_WK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) route_o <= '0;
    else if (wr_i) route_o <= wdata_i & RT_MASK;
  end

  a_r9_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_o & ~RT_MASK) == '0);
endmodule

// File: rtl/wkup_rd_mux.sv
module wkup_rd_mux
  import wkup_irq_pkg::*;
#(
  parameter int unsigned NCH = N_CHAN
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           rd_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [NCH-1:0] status_i,
  input  logic [NCH-1:0] enable_i,
  input  logic [DW-1:0]  route_i,
  output logic [DW-1:0]  rdata_o
);
  logic [DW-1:0] sel;
  always_comb begin
    unique case (addr_i)
      OFF_STS: sel = DW'(status_i);
      OFF_EN:  sel = DW'(enable_i);
      OFF_RT:  sel = route_i;
      default: sel = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else rdata_o <= rd_i ? sel : '0;
  end

  a_r10_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (rdata_o == '0));
endmodule

// File: rtl/wkup_irq_ctrl.sv
module wkup_irq_ctrl
  import wkup_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [N_CHAN-1:0] chan_evt_i,
  input  logic [N_PER-1:0]  per_evt_i,
  output logic              ext_irq_o,
  output logic [N_CHAN-1:0] chan_irq_o,
  output logic [N_PER-1:0]  per_irq_o,
  output logic              wake_o
);
  wr_sel_t          wr;
  logic [N_CHAN-1:0] status, enable;
  logic [DW-1:0]    route;
  logic [N_CHAN-1:0] chan_pend;

  assign wr.sts = req_i && we_i && (addr_i == OFF_STS);
  assign wr.en  = req_i && we_i && (addr_i == OFF_EN);
  assign wr.clr = req_i && we_i && (addr_i == OFF_CLR);
  assign wr.rt  = req_i && we_i && (addr_i == OFF_RT);

  wkup_chan_status #(.NCH(N_CHAN)) u_status (
    .clk_i, .rst_ni,
    .wr_en_i (wr.en),
    .wr_clr_i(wr.clr),
    .wdata_i (wdata_i[N_CHAN-1:0]),
    .evt_i   (chan_evt_i),
    .status_o(status),
    .enable_o(enable)
  );

  wkup_route_reg #(.NCH(N_CHAN), .NPR(N_PER)) u_route (
    .clk_i, .rst_ni,
    .wr_i   (wr.rt),
    .wdata_i(wdata_i),
    .route_o(route)
  );

  wkup_rd_mux #(.NCH(N_CHAN)) u_rd (
    .clk_i, .rst_ni,
    .rd_i    (req_i && !we_i),
    .addr_i  (addr_i),
    .status_i(status),
    .enable_i(enable),
    .route_i (route),
    .rdata_o (rdata_o)
  );

  assign chan_pend  = status & enable;
  assign ext_irq_o  = |chan_pend;
  assign chan_irq_o = chan_pend & route[RT_CHAN_EXT +: N_CHAN];
  assign per_irq_o  = per_evt_i & route[RT_PER_EXT +: N_PER];
  assign wake_o     = |(status & route[RT_CHAN_WK +: N_CHAN])
                    | |(per_evt_i & route[RT_PER_WK +: N_PER]);

  a_r5_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable == '0) |-> !ext_irq_o);

  a_r5_mask_keeps_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr.en && !wr.clr) |=> ((status & $past(status)) == $past(status)));

  a_r11_status_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr.sts && chan_evt_i == '0) |=> (status == $past(status)));

  a_r6_route_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_irq_o & ~status) == '0);
endmodule

// File: tb/wkup_irq_ctrl_tb_top.sv
module wkup_irq_ctrl_tb_top;
  import wkup_irq_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wd = '0, rdata;
  logic [3:0] ce = '0;
  logic [2:0] pe = '0;
  logic ext_irq, wake;
  logic [3:0] chan_irq;
  logic [2:0] per_irq;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [3:0]  m_sts = '0, m_en = '0;
  logic [31:0] m_rt = '0;
  localparam logic [31:0] RT_MASK = 32'h0F07_0F07;

  always #5 clk = ~clk;

  wkup_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wd), .rdata_o(rdata), .chan_evt_i(ce), .per_evt_i(pe),
    .ext_irq_o(ext_irq), .chan_irq_o(chan_irq), .per_irq_o(per_irq), .wake_o(wake)
  );

  task automatic chk(string req_tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_model(logic [AW-1:0] a);
    case (a)
      OFF_STS: return {28'h0, m_sts};
      OFF_EN:  return {28'h0, m_en};
      OFF_RT:  return m_rt;
      default: return 32'h0;
    endcase
  endfunction

  // drive at negedge, predict, check just after posedge
  task automatic step(logic r, logic w, logic [AW-1:0] a, logic [31:0] d,
                      logic [3:0] c, logic [2:0] p, string tag);
    logic [31:0] exp_rd;
    logic [3:0] clr;
    @(negedge clk);
    req = r; we = w; addr = a; wd = d; ce = c; pe = p;
    exp_rd = (r && !w) ? rd_model(a) : 32'h0;
    clr = (r && w && a == OFF_CLR) ? d[3:0] : 4'h0;
    @(posedge clk); #1;
    m_sts = (m_sts & ~clr) | c;
    if (r && w && a == OFF_EN) m_en = d[3:0];
    if (r && w && a == OFF_RT) m_rt = d & RT_MASK;
    chk({tag, " R10 rdata"}, rdata, exp_rd);
    chk("R5 ext_irq", {31'h0, ext_irq}, {31'h0, |(m_sts & m_en)});
    chk("R6 chan_irq", {28'h0, chan_irq}, {28'h0, m_sts & m_en & m_rt[11:8]});
    chk("R7 per_irq", {29'h0, per_irq}, {29'h0, pe & m_rt[2:0]});
    chk("R8 wake", {31'h0, wake},
        {31'h0, (|(m_sts & m_rt[27:24])) | (|(pe & m_rt[18:16]))});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ext_irq", {31'h0, ext_irq}, 32'h0);
    chk("R1 wake", {31'h0, wake}, 32'h0);
    chk("R1 chan_irq", {28'h0, chan_irq}, 32'h0);
    rst_n = 1'b1;
    step(1, 0, OFF_STS, 0, 0, 0, "R1");
    step(1, 0, OFF_EN,  0, 0, 0, "R1");
    step(1, 0, OFF_RT,  0, 0, 0, "R1");
    // R9 reserved bits
    step(1, 1, OFF_RT, 32'hFFFF_FFFF, 0, 0, "R9");
    step(1, 0, OFF_RT, 0, 0, 3'b101, "R9");
    step(1, 1, OFF_EN, 32'hFFFF_FFFF, 0, 0, "R9");
    step(1, 0, OFF_EN, 0, 0, 0, "R9");
    // R2 latch and hold
    step(0, 0, 0, 0, 4'b0101, 0, "R2");
    step(1, 0, OFF_STS, 0, 0, 0, "R2");
    // R11 status write ignored
    step(1, 1, OFF_STS, 32'h0, 0, 0, "R11");
    step(1, 0, OFF_STS, 0, 0, 0, "R11");
    // R5 mask keeps status
    step(1, 1, OFF_EN, 0, 0, 0, "R5");
    step(1, 0, OFF_STS, 0, 0, 0, "R5");
    step(1, 1, OFF_EN, 32'hF, 0, 0, "R5");
    // R4 collision, R3 clear partial
    step(1, 1, OFF_CLR, 32'h5, 4'b0100, 0, "R4");
    step(1, 0, OFF_STS, 0, 0, 0, "R4");
    step(1, 1, OFF_CLR, 32'h0, 0, 0, "R3");
    step(1, 0, OFF_CLR, 0, 0, 0, "R3");
    step(1, 1, OFF_CLR, 32'hF, 0, 0, "R3");
    step(1, 0, OFF_STS, 0, 0, 0, "R3");
    // R10 unmapped
    step(1, 0, 12'h320, 0, 0, 0, "R10");
    step(1, 0, 12'h000, 0, 0, 0, "R10");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a;
      logic [3:0] c;
      case ($urandom % 6)
        0: a = OFF_STS; 1: a = OFF_EN; 2: a = OFF_CLR;
        3: a = OFF_RT;  4: a = OFF_CLR; default: a = 12'(($urandom % 1024) << 2);
      endcase
      c = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
      step(1'($urandom % 4 != 0), 1'($urandom), a, $urandom, c, 3'($urandom), "R2");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule